// File: doc/BRIEF.md
# CAN controller status and error tracker

This block holds the 16-bit status word of a CAN protocol controller. The protocol engine feeds it single-cycle event strobes: a frame received, a frame transmitted and acknowledged, an error report carrying a type code, and a tick for each run of 11 recessive bits seen while the node recovers from bus-off. It also receives the live transmit and receive error counter values, an error-passive level and a bus-off level. From these it derives the warning, error-passive and bus-off flags, keeps two sticky success flags and records the type of the last bus event.

Software reads the word through a plain register port and may write it. A write of 0 to a success flag clears it. A write to the event-code field loads any value. The value 7 works as a marker: it stays until the engine reports a new bus event. The three level flags cannot be written. The read port is combinational from the status registers. Every status bit changes on the clock edge that samples its cause, so a strobe in cycle N shows in the readback in cycle N+1. No stream data passes through the block, so it has no valid/ready handshake.

Top module: `can_stat_tracker`

## Requirements
- R1: After synchronous reset the readback is 0x0000. Bits 15:8 always read 0. The layout is bit 7 bus-off, bit 6 warning, bit 5 error-passive, bit 4 receive-ok, bit 3 transmit-ok, and bits 2:0 the event code.
- R2: Bit 6 is 1 one cycle after either error counter is at or above 96. It is 0 one cycle after both counters are below 96.
- R3: Bit 5 is 1 one cycle after either counter is at or above 128, or after the error-passive input is high. Otherwise it is 0.
- R4: Bit 7 follows the bus-off input with one cycle of delay. CPU writes to bits 7:5 have no effect.
- R5: A receive strobe sets bit 4. Only a CPU write with bit 4 = 0 clears it. A CPU write with bit 4 = 1 does not set it.
- R6: A transmit-acknowledged strobe sets bit 3. Only a CPU write with bit 3 = 0 clears it. A CPU write with bit 3 = 1 does not set it.
- R7: An error strobe with a code from 1 to 6 loads that code into bits 2:0. The codes are 1 stuff, 2 form, 3 acknowledge, 4 Bit1, 5 Bit0 and 6 CRC. An error strobe carrying code 0 or 7 leaves the field unchanged.
- R8: A receive or transmit strobe loads event code 0. If a valid error strobe comes in the same cycle, the error code is loaded instead.
- R9: A CPU write loads bits 2:0 with the written value. A written 7 stays until the next bus event.
- R10: A recovery tick while the bus-off input is high loads event code 5. A tick while the bus-off input is low is ignored. A valid error strobe in the same cycle takes priority over the tick.
- R11: A core event in the same cycle as a CPU write wins. A set strobe keeps its flag at 1 against a clearing write, and a core event code replaces the written code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_ok_stb | input | 1 | Frame received successfully |
| tx_ok_stb | input | 1 | Frame transmitted and acknowledged |
| err_stb | input | 1 | Error report strobe |
| err_code | input | 3 | Error type carried by err_stb |
| recov_tick | input | 1 | 11 recessive bits seen during recovery |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| passive_in | input | 1 | Error-passive level from the engine |
| busoff_in | input | 1 | Bus-off level from the engine |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Status word readback |

## Verification
The bench drives the counters across the 95/96 and 127/128 boundaries, one counter at a time. A design that compared with the wrong operator, or that required both counters to be high, would show the wrong warning or passive bit exactly at the threshold. It raises strobes in the same cycle as CPU writes and as each other. A design with the wrong priority would lose a sticky flag to a clearing write, or record 0 or 5 where the error code belongs. It writes the 7 marker, then sends ignored stimuli: idle cycles, invalid error codes, and a recovery tick outside bus-off. A design that treated any of them as an event would overwrite the marker.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

  localparam int STAT_W  = 16;
  localparam int CODE_W  = 3;

  localparam int BIT_BOFF  = 7;
  localparam int BIT_WARN  = 6;
  localparam int BIT_PASS  = 5;
  localparam int BIT_RXOK  = 4;
  localparam int BIT_TXOK  = 3;

  localparam int NUM_OK = 2;
  localparam int OK_RX  = 1;
  localparam int OK_TX  = 0;

  typedef enum logic [CODE_W-1:0] {
    EV_NONE  = 3'd0,
    EV_STUFF = 3'd1,
    EV_FORM  = 3'd2,
    EV_ACK   = 3'd3,
    EV_BIT1  = 3'd4,
    EV_BIT0  = 3'd5,
    EV_CRC   = 3'd6,
    EV_MARK  = 3'd7
  } ev_code_e;

  function automatic logic code_is_error(input logic [CODE_W-1:0] c);
    return (c != EV_NONE) && (c != EV_MARK);
  endfunction

endpackage

// File: rtl/can_err_level.sv
module can_err_level #(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             passive_in,
  input  logic             busoff_in,
  output logic             warn_q,
  output logic             pass_q,
  output logic             boff_q
);

  localparam int NCNT = 2;
  localparam logic [CNT_W-1:0] WARN_V = WARN_LIM[CNT_W-1:0];
  localparam logic [CNT_W-1:0] PASS_V = PASS_LIM[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_arr [NCNT];
  logic [NCNT-1:0]  over_warn;
  logic [NCNT-1:0]  over_pass;

  assign cnt_arr[0] = tx_cnt;
  assign cnt_arr[1] = rx_cnt;

  for (genvar i = 0; i < NCNT; i++) begin : g_cmp
    assign over_warn[i] = (cnt_arr[i] >= WARN_V);
    assign over_pass[i] = (cnt_arr[i] >= PASS_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q <= 1'b0;
      pass_q <= 1'b0;
      boff_q <= 1'b0;
    end else begin
      warn_q <= |over_warn;
      pass_q <= (|over_pass) | passive_in;
      boff_q <= busoff_in;
    end
  end

endmodule

// File: rtl/can_sticky_flags.sv
module can_sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_stb,
  input  logic         wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr_req;
    assign clr_req = wr & ~wbits[i];
    always_ff @(posedge clk) begin
      if (rst)             flags[i] <= 1'b0;
      else if (set_stb[i]) flags[i] <= 1'b1;
      else if (clr_req)    flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/can_lec_keeper.sv
module can_lec_keeper
  import can_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              err_stb,
  input  logic [CODE_W-1:0] err_code,
  input  logic              recov_tick,
  input  logic              busoff_in,
  input  logic              ok_stb,
  input  logic              cpu_wr,
  input  logic [CODE_W-1:0] cpu_code,
  output logic [CODE_W-1:0] lec
);

  logic              err_hit;
  logic              recov_hit;
  logic              load;
  logic [CODE_W-1:0] next_code;

  assign err_hit   = err_stb & code_is_error(err_code);
  assign recov_hit = recov_tick & busoff_in;

  always_comb begin
    load      = 1'b1;
    next_code = lec;
    if (err_hit)        next_code = err_code;
    else if (recov_hit) next_code = EV_BIT0;
    else if (ok_stb)    next_code = EV_NONE;
    else if (cpu_wr)    next_code = cpu_code;
    else                load      = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       lec <= EV_NONE;
    else if (load) lec <= next_code;
  end

endmodule

// File: rtl/can_stat_tracker.sv
module can_stat_tracker
  import can_stat_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_ok_stb,
  input  logic              tx_ok_stb,
  input  logic              err_stb,
  input  logic [2:0]        err_code,
  input  logic              recov_tick,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic              passive_in,
  input  logic              busoff_in,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_wdata,
  output logic [15:0]       cpu_rdata
);

  logic              warn_q, pass_q, boff_q;
  logic [NUM_OK-1:0] ok_set, ok_wbits, ok_flags;
  logic [CODE_W-1:0] lec;

  can_err_level #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
  ) u_level (
    .clk(clk), .rst(rst),
    .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
    .passive_in(passive_in), .busoff_in(busoff_in),
    .warn_q(warn_q), .pass_q(pass_q), .boff_q(boff_q)
  );

  assign ok_set[OK_RX]   = rx_ok_stb;
  assign ok_set[OK_TX]   = tx_ok_stb;
  assign ok_wbits[OK_RX] = cpu_wdata[BIT_RXOK];
  assign ok_wbits[OK_TX] = cpu_wdata[BIT_TXOK];

  can_sticky_flags #(.N(NUM_OK)) u_ok (
    .clk(clk), .rst(rst),
    .set_stb(ok_set), .wr(cpu_wr), .wbits(ok_wbits),
    .flags(ok_flags)
  );

  can_lec_keeper u_lec (
    .clk(clk), .rst(rst),
    .err_stb(err_stb), .err_code(err_code),
    .recov_tick(recov_tick), .busoff_in(busoff_in),
    .ok_stb(rx_ok_stb | tx_ok_stb),
    .cpu_wr(cpu_wr), .cpu_code(cpu_wdata[CODE_W-1:0]),
    .lec(lec)
  );

  always_comb begin
    cpu_rdata                   = '0;
    cpu_rdata[BIT_BOFF]         = boff_q;
    cpu_rdata[BIT_WARN]         = warn_q;
    cpu_rdata[BIT_PASS]         = pass_q;
    cpu_rdata[BIT_RXOK]         = ok_flags[OK_RX];
    cpu_rdata[BIT_TXOK]         = ok_flags[OK_TX];
    cpu_rdata[CODE_W-1:0]       = lec;
  end

endmodule

// File: rtl/can_stat_tracker_chk.sv
module can_stat_tracker_chk #(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_ok_stb,
  input logic             tx_ok_stb,
  input logic             err_stb,
  input logic [2:0]       err_code,
  input logic             recov_tick,
  input logic [CNT_W-1:0] tx_err_cnt,
  input logic [CNT_W-1:0] rx_err_cnt,
  input logic             passive_in,
  input logic             busoff_in,
  input logic             cpu_wr,
  input logic [15:0]      cpu_wdata,
  input logic [15:0]      cpu_rdata
);

  logic err_ok, any_warn, any_pass, any_core;
  assign err_ok   = err_stb && (err_code != 3'd0) && (err_code != 3'd7);
  assign any_warn = (int'(tx_err_cnt) >= WARN_LIM) || (int'(rx_err_cnt) >= WARN_LIM);
  assign any_pass = (int'(tx_err_cnt) >= PASS_LIM) || (int'(rx_err_cnt) >= PASS_LIM) || passive_in;
  assign any_core = err_ok || (recov_tick && busoff_in) || rx_ok_stb || tx_ok_stb;

  always_comb if (!rst) AST_RSVD_ZERO: assert (cpu_rdata[15:8] == 8'h00); // R1

  AST_WARN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cpu_rdata[6] == $past(any_warn)); // R2
  AST_PASS_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cpu_rdata[5] == $past(any_pass)); // R3
  AST_BOFF_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cpu_rdata[7] == $past(busoff_in)); // R4
  AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
    rx_ok_stb |=> cpu_rdata[4]); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata[4] && !(cpu_wr && !cpu_wdata[4])) |=> cpu_rdata[4]); // R5
  AST_TX_SET: assert property (@(posedge clk) disable iff (rst)
    tx_ok_stb |=> cpu_rdata[3]); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata[3] && !(cpu_wr && !cpu_wdata[3])) |=> cpu_rdata[3]); // R6
  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    err_ok |=> cpu_rdata[2:0] == $past(err_code)); // R7
  AST_OK_CODE: assert property (@(posedge clk) disable iff (rst)
    ((rx_ok_stb || tx_ok_stb) && !err_ok && !(recov_tick && busoff_in))
    |=> cpu_rdata[2:0] == 3'd0); // R8
  AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!any_core && !cpu_wr) |=> $stable(cpu_rdata[2:0])); // R9
  AST_RECOV_CODE: assert property (@(posedge clk) disable iff (rst)
    (recov_tick && busoff_in && !err_ok) |=> cpu_rdata[2:0] == 3'd5); // R10

endmodule

bind can_stat_tracker can_stat_tracker_chk #(
  .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)
) u_chk (
  .clk(clk), .rst(rst), .rx_ok_stb(rx_ok_stb), .tx_ok_stb(tx_ok_stb),
  .err_stb(err_stb), .err_code(err_code), .recov_tick(recov_tick),
  .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
  .passive_in(passive_in), .busoff_in(busoff_in),
  .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
);

// File: tb/can_stat_tracker_test.sv
module can_stat_tracker_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx_ok_stb = 0, tx_ok_stb = 0, err_stb = 0, recov_tick = 0;
  logic [2:0]       err_code = 0;
  logic [CNT_W-1:0] tx_err_cnt = 0, rx_err_cnt = 0;
  logic             passive_in = 0, busoff_in = 0;
  logic             cpu_wr = 0;
  logic [15:0]      cpu_wdata = 0;
  logic [15:0]      cpu_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stat_tracker #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .rx_ok_stb(rx_ok_stb), .tx_ok_stb(tx_ok_stb),
    .err_stb(err_stb), .err_code(err_code), .recov_tick(recov_tick),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .passive_in(passive_in), .busoff_in(busoff_in),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %04h expected %04h", req, act, exp);
    end
  endtask

  task automatic cpu_write(logic [15:0] d);
    cpu_wr = 1; cpu_wdata = d; step(); cpu_wr = 0; cpu_wdata = 0;
  endtask

  task automatic do_reset();
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic err_pulse(logic [2:0] c);
    err_stb = 1; err_code = c; step(); err_stb = 0; err_code = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset word", cpu_rdata, 16'h0000);
    cpu_write(16'hFF00);
    check("R1 reserved read zero", cpu_rdata, 16'h0000);
  endtask

  task automatic t_warn();
    do_reset();
    tx_err_cnt = 95; step();
    check("R2 tx 95", {15'd0, cpu_rdata[6]}, 16'd0);
    tx_err_cnt = 96; step();
    check("R2 tx 96", {15'd0, cpu_rdata[6]}, 16'd1);
    tx_err_cnt = 0; rx_err_cnt = 96; step();
    check("R2 rx 96", {15'd0, cpu_rdata[6]}, 16'd1);
    rx_err_cnt = 95; step();
    check("R2 both below", {15'd0, cpu_rdata[6]}, 16'd0);
    rx_err_cnt = 0;
  endtask

  task automatic t_pass();
    do_reset();
    rx_err_cnt = 127; step();
    check("R3 rx 127", cpu_rdata & 16'h0060, 16'h0040);
    rx_err_cnt = 128; step();
    check("R3 rx 128", cpu_rdata & 16'h0060, 16'h0060);
    rx_err_cnt = 0; tx_err_cnt = 200; step();
    check("R3 tx 200", {15'd0, cpu_rdata[5]}, 16'd1);
    tx_err_cnt = 0; passive_in = 1; step();
    check("R3 passive input", cpu_rdata, 16'h0020);
    passive_in = 0; step();
    check("R3 active", cpu_rdata, 16'h0000);
  endtask

  task automatic t_boff();
    do_reset();
    cpu_write(16'h00E0);
    check("R4 write ignored", cpu_rdata, 16'h0000);
    busoff_in = 1; step();
    check("R4 boff set", cpu_rdata, 16'h0080);
    cpu_write(16'h0000);
    check("R4 write no clear", cpu_rdata, 16'h0080);
    busoff_in = 0; step();
    check("R4 boff clear", cpu_rdata, 16'h0000);
  endtask

  task automatic t_rx();
    do_reset();
    cpu_write(16'h0010);
    check("R5 write 1 no set", cpu_rdata, 16'h0000);
    rx_ok_stb = 1; step(); rx_ok_stb = 0;
    check("R5 set", cpu_rdata, 16'h0010);
    step(); step();
    check("R5 sticky", cpu_rdata, 16'h0010);
    cpu_write(16'h0010);
    check("R5 write 1 keeps", cpu_rdata, 16'h0010);
    cpu_write(16'h0000);
    check("R5 clear", cpu_rdata, 16'h0000);
  endtask

  task automatic t_tx();
    do_reset();
    tx_ok_stb = 1; step(); tx_ok_stb = 0;
    check("R6 set", cpu_rdata, 16'h0008);
    step();
    check("R6 sticky", cpu_rdata, 16'h0008);
    cpu_write(16'h0010);
    check("R6 clear by 0", cpu_rdata, 16'h0000);
  endtask

  task automatic t_codes();
    do_reset();
    for (int c = 1; c <= 6; c++) begin
      err_pulse(3'(c));
      check("R7 code load", cpu_rdata, 16'(c));
    end
    err_pulse(3'd0);
    check("R7 code 0 ignored", cpu_rdata, 16'h0006);
    err_pulse(3'd7);
    check("R7 code 7 ignored", cpu_rdata, 16'h0006);
  endtask

  task automatic t_ok_prio();
    do_reset();
    err_pulse(3'd3);
    rx_ok_stb = 1; step(); rx_ok_stb = 0;
    check("R8 success zero code", cpu_rdata, 16'h0010);
    tx_ok_stb = 1; err_stb = 1; err_code = 3'd2; step();
    tx_ok_stb = 0; err_stb = 0; err_code = 0;
    check("R8 error beats success", cpu_rdata, 16'h001A);
  endtask

  task automatic t_marker();
    do_reset();
    err_pulse(3'd4);
    cpu_write(16'h0007);
    check("R9 marker written", cpu_rdata, 16'h0007);
    step(); step(); step();
    err_pulse(3'd0);
    recov_tick = 1; step(); recov_tick = 0;
    check("R9 marker held", cpu_rdata, 16'h0007);
    cpu_write(16'h0002);
    check("R9 any value", cpu_rdata, 16'h0002);
    cpu_write(16'h0007);
    err_pulse(3'd6);
    check("R9 event replaces marker", cpu_rdata, 16'h0006);
  endtask

  task automatic t_recov();
    do_reset();
    cpu_write(16'h0007);
    recov_tick = 1; step(); recov_tick = 0;
    check("R10 tick outside bus-off", cpu_rdata, 16'h0007);
    busoff_in = 1; step();
    cpu_write(16'h0007);
    recov_tick = 1; step(); recov_tick = 0;
    check("R10 tick in bus-off", cpu_rdata, 16'h0085);
    recov_tick = 1; err_stb = 1; err_code = 3'd1; step();
    recov_tick = 0; err_stb = 0; err_code = 0;
    check("R10 error beats tick", cpu_rdata, 16'h0081);
    busoff_in = 0; step();
  endtask

  task automatic t_cpu_race();
    do_reset();
    rx_ok_stb = 1; step(); rx_ok_stb = 0;
    rx_ok_stb = 1; cpu_wr = 1; cpu_wdata = 16'h0003; step();
    rx_ok_stb = 0; cpu_wr = 0; cpu_wdata = 0;
    check("R11 set beats clear", cpu_rdata, 16'h0010);
    err_stb = 1; err_code = 3'd5; cpu_wr = 1; cpu_wdata = 16'h0017; step();
    err_stb = 0; err_code = 0; cpu_wr = 0; cpu_wdata = 0;
    check("R11 event code beats write", cpu_rdata, 16'h0015);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_warn();
    t_pass();
    t_boff();
    t_rx();
    t_tx();
    t_codes();
    t_ok_prio();
    t_marker();
    t_recov();
    t_cpu_race();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule